// File: doc/BRIEF.md
# Bus-Seeded Maximal-Length Pseudo-Random Generator

This block produces a stream of pseudo-random 32-bit words from a linear feedback shift register whose feedback polynomial, x^32 + x^22 + x^2 + x + 1, gives the longest possible cycle of 2^32 - 1 states. The register advances by one step on every clock, and its full state is driven onto an output port at all times.

A host reaches the block through a small Wishbone classic slave with an 8-bit data bus. It writes a seed one byte at a time, for example bytes taken from an external physical noise source. It then writes a command word that either copies the assembled seed into the shift register or returns the register to its fixed start value. A zero seed is never loaded as zero, so the register cannot lock up in the all-zero state.

Top module: `lfsr_prng_top`

## Requirements
- R1: While the reset is active, `state_o` is 32'h0000_0001, `wb_ack_o` is 0 and all seed bytes read back as 0. Asserting the reset forces `state_o` to 32'h0000_0001 at once, without waiting for a clock edge. After the reset is released, the block stays in reset for two more clock edges.
- R2: In every cycle with no command, `state_o` shifts left by one place. The new bit 0 is the XOR of old bits 31, 21, 1 and 0.
- R3: A write to address 0, 1, 2 or 3 stores the data byte as seed bits 7:0, 15:8, 23:16 or 31:24, in that order. A read of the same address returns the stored byte.
- R4: A write to address 4 with bit 1 set and bit 0 clear sets `state_o` to the assembled seed on the clock edge that accepts the write. Stepping resumes from the loaded value.
- R5: Loading a seed of zero sets `state_o` to 32'h0000_0001. `state_o` is never zero.
- R6: A write to address 4 with bit 0 set sets `state_o` to 32'h0000_0001 on the accepting edge, whatever the value of bit 1. The command bits are not stored, so each write acts once.
- R7: `wb_ack_o` goes high in the cycle after `wb_cyc_i` and `wb_stb_i` are first seen high together. It stays high for exactly one cycle per access.
- R8: Reads of addresses 4 to 7 return zero. Writes to addresses 5 to 7 change neither the seed bytes nor `state_o`.
- R9: `wb_stb_i` without `wb_cyc_i` is neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with ack |
| wb_ack_o | output | 1 | Access acknowledge |
| state_o | output | 32 | Current generator state |

## Verification
The bench builds the block with its default parameters: a 32-bit state, an 8-bit data bus and the tap mask 32'h8020_0003. These give four seed byte addresses and one command address, so the 3-bit address field can also reach the three unmapped addresses, 5 to 7. With these values, every single-step transition, the byte-to-bit placement of the seed, the command priority and the zero-seed substitution can all be checked directly. The full 2^32 - 1 cycle length is too long to reach in simulation. Instead, the feedback taps are checked against a reference model on every clock.

// File: rtl/lfsr_prng_pkg.sv
package lfsr_prng_pkg;

  // bit positions inside the command register
  localparam int unsigned CMD_CLR_BIT  = 0;
  localparam int unsigned CMD_LOAD_BIT = 1;

  typedef struct packed {
    logic clr;
    logic load;
  } lfsr_cmd_t;

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/lfsr_wb_regs.sv
module lfsr_wb_regs
  import lfsr_prng_pkg::*;
#(
  parameter int unsigned DAT_W   = 8,
  parameter int unsigned N_BYTES = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wb_cyc_i,
  input  logic                       wb_stb_i,
  input  logic                       wb_we_i,
  input  logic [ADDR_W-1:0]          wb_adr_i,
  input  logic [DAT_W-1:0]           wb_dat_i,
  output logic [DAT_W-1:0]           wb_dat_o,
  output logic                       wb_ack_o,
  output logic [N_BYTES*DAT_W-1:0]   seed_o,
  output lfsr_cmd_t                  cmd_o
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(N_BYTES);

  logic                             ack_q, ack_d;
  logic [DAT_W-1:0]                 dat_q, dat_d;
  logic [N_BYTES-1:0][DAT_W-1:0]    seed_q;
  logic                             req, wr_en;
  logic [DAT_W-1:0]                 rd_mux;

  assign req   = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr_en = req & wb_we_i;

  // one register per seed byte, each with its own enable
  for (genvar g = 0; g < N_BYTES; g++) begin : g_seed
    logic             en;
    logic [DAT_W-1:0] d;
    assign en = wr_en & (wb_adr_i == ADDR_W'(g));
    always_comb begin
      d = en ? wb_dat_i : seed_q[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seed_q[g] <= '0;
      else         seed_q[g] <= d;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_BYTES; i++) begin
      if (wb_adr_i == ADDR_W'(i)) rd_mux = seed_q[i];
    end
  end

  always_comb begin
    ack_d = req;
    dat_d = req ? rd_mux : dat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_d;
      dat_q <= dat_d;
    end
  end

  // command bits act on the accepting edge and are never stored
  always_comb begin
    cmd_o.clr  = wr_en & (wb_adr_i == CMD_ADDR) & wb_dat_i[CMD_CLR_BIT];
    cmd_o.load = wr_en & (wb_adr_i == CMD_ADDR) & wb_dat_i[CMD_LOAD_BIT];
  end

  assign seed_o   = seed_q;
  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
  import lfsr_prng_pkg::*;
#(
  parameter int unsigned         STATE_W  = 32,
  parameter logic [STATE_W-1:0]  TAP_MASK = 32'h8020_0003,
  parameter logic [STATE_W-1:0]  RST_VAL  = 32'h0000_0001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  lfsr_cmd_t           cmd_i,
  input  logic [STATE_W-1:0]  seed_i,
  output logic [STATE_W-1:0]  state_o
);

  logic [STATE_W-1:0] state_q, state_d, step_val, load_val;
  logic               fb;

  always_comb begin
    fb       = ^(state_q & TAP_MASK);
    step_val = {state_q[STATE_W-2:0], fb};
    load_val = (seed_i == '0) ? RST_VAL : seed_i;
  end

  // reset command outranks load, load outranks stepping
  always_comb begin
    if (cmd_i.clr)       state_d = RST_VAL;
    else if (cmd_i.load) state_d = load_val;
    else                 state_d = step_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_VAL;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/lfsr_prng_top.sv
module lfsr_prng_top
  import lfsr_prng_pkg::*;
#(
  parameter int unsigned         STATE_W  = 32,
  parameter int unsigned         DAT_W    = 8,
  parameter logic [STATE_W-1:0]  TAP_MASK = 32'h8020_0003,
  parameter logic [STATE_W-1:0]  RST_VAL  = 32'h0000_0001,
  localparam int unsigned        N_BYTES  = STATE_W / DAT_W,
  localparam int unsigned        ADDR_W   = $clog2(N_BYTES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADDR_W-1:0]   wb_adr_i,
  input  logic [DAT_W-1:0]    wb_dat_i,
  output logic [DAT_W-1:0]    wb_dat_o,
  output logic                wb_ack_o,
  output logic [STATE_W-1:0]  state_o
);

  logic               rst_int_n;
  logic [STATE_W-1:0] seed;
  lfsr_cmd_t          cmd;

  lfsr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  lfsr_wb_regs #(
    .DAT_W   (DAT_W),
    .N_BYTES (N_BYTES),
    .ADDR_W  (ADDR_W)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .wb_cyc_i (wb_cyc_i),
    .wb_stb_i (wb_stb_i),
    .wb_we_i  (wb_we_i),
    .wb_adr_i (wb_adr_i),
    .wb_dat_i (wb_dat_i),
    .wb_dat_o (wb_dat_o),
    .wb_ack_o (wb_ack_o),
    .seed_o   (seed),
    .cmd_o    (cmd)
  );

  lfsr_core #(
    .STATE_W  (STATE_W),
    .TAP_MASK (TAP_MASK),
    .RST_VAL  (RST_VAL)
  ) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .cmd_i   (cmd),
    .seed_i  (seed),
    .state_o (state_o)
  );

endmodule

// File: rtl/lfsr_prng_chk.sv
module lfsr_prng_chk #(
  parameter int unsigned         STATE_W  = 32,
  parameter int unsigned         DAT_W    = 8,
  parameter int unsigned         ADDR_W   = 3,
  parameter logic [STATE_W-1:0]  TAP_MASK = 32'h8020_0003,
  parameter logic [STATE_W-1:0]  RST_VAL  = 32'h0000_0001
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rst_int_n,
  input logic                wb_cyc_i,
  input logic                wb_stb_i,
  input logic                wb_we_i,
  input logic [ADDR_W-1:0]   wb_adr_i,
  input logic [DAT_W-1:0]    wb_dat_i,
  input logic [DAT_W-1:0]    wb_dat_o,
  input logic                wb_ack_o,
  input logic [STATE_W-1:0]  seed,
  input logic [STATE_W-1:0]  state_o
);

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(STATE_W / DAT_W);

  logic acc, cmd_wr;
  assign acc    = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign cmd_wr = acc & wb_we_i & (wb_adr_i == CMD_A) & (wb_dat_i[1] | wb_dat_i[0]);

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_int_n && !cmd_wr) |=> state_o == {$past(state_o[STATE_W-2:0]), ^($past(state_o) & TAP_MASK)}); // R2

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_int_n && cmd_wr && !wb_dat_i[0] && seed != '0) |=> state_o == $past(seed)); // R4

  AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0); // R5

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_int_n && cmd_wr && wb_dat_i[0]) |=> state_o == RST_VAL); // R6

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_int_n && acc) |=> wb_ack_o); // R7

  AST_ACK_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R7

  AST_HIGH_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_int_n && acc && !wb_we_i && wb_adr_i >= CMD_A) |=> wb_dat_o == '0); // R8

  AST_NO_CYC_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_cyc_i && wb_stb_i) |=> !wb_ack_o); // R9

endmodule

bind lfsr_prng_top lfsr_prng_chk #(
  .STATE_W  (STATE_W),
  .DAT_W    (DAT_W),
  .ADDR_W   (ADDR_W),
  .TAP_MASK (TAP_MASK),
  .RST_VAL  (RST_VAL)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_int_n (rst_int_n),
  .wb_cyc_i  (wb_cyc_i),
  .wb_stb_i  (wb_stb_i),
  .wb_we_i   (wb_we_i),
  .wb_adr_i  (wb_adr_i),
  .wb_dat_i  (wb_dat_i),
  .wb_dat_o  (wb_dat_o),
  .wb_ack_o  (wb_ack_o),
  .seed      (seed),
  .state_o   (state_o)
);

// File: tb/test_lfsr_prng_top.sv
`timescale 1ns/1ps
module test_lfsr_prng_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc, stb, we;
  logic [2:0]  adr;
  logic [7:0]  dat_i;
  logic [7:0]  dat_o;
  logic        ack;
  logic [31:0] state;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  lfsr_prng_top i_lfsr_prng_top (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wb_cyc_i (cyc),
    .wb_stb_i (stb),
    .wb_we_i  (we),
    .wb_adr_i (adr),
    .wb_dat_i (dat_i),
    .wb_dat_o (dat_o),
    .wb_ack_o (ack),
    .state_o  (state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_seed [4];
  logic [31:0] m_state;
  logic        m_ack;
  int          m_rel;

  function automatic logic [31:0] ref_step(input logic [31:0] s);
    int taps [4] = '{31, 21, 1, 0};
    logic fb = 1'b0;
    foreach (taps[k]) fb ^= s[taps[k]];
    return {s[30:0], fb};
  endfunction

  task automatic model_reset();
    foreach (m_seed[k]) m_seed[k] = 8'h00;
    m_state = 32'h1;
    m_ack   = 1'b0;
    m_rel   = 0;
  endtask

  always @(negedge rst_n) model_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_reset();
    else if (m_rel < 2) begin
      m_rel++;
      model_reset_keep();
    end else begin
      logic [31:0] nxt, sw;
      logic        req;
      req = cyc && stb && !m_ack;
      nxt = ref_step(m_state);
      sw  = {m_seed[3], m_seed[2], m_seed[1], m_seed[0]};
      if (req && we) begin
        if (adr < 3'd4) m_seed[adr] = dat_i;
        else if (adr == 3'd4) begin
          if (dat_i[0])      nxt = 32'h1;
          else if (dat_i[1]) nxt = (sw == 0) ? 32'h1 : sw;
        end
      end
      m_state = nxt;
      m_ack   = req;
    end
  end

  task automatic model_reset_keep();
    int keep = m_rel;
    model_reset();
    m_rel = keep;
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 state vs model", state, m_state);
      check("R7 ack vs model", {31'b0, ack}, {31'b0, m_ack});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wb_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; dat_i = d;
    @(negedge clk);
    check("R7 write ack", {31'b0, ack}, 32'd1);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    @(negedge clk);
    check("R7 read ack", {31'b0, ack}, 32'd1);
    d = dat_o;
    cyc = 0; stb = 0;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'h0F, 8'hE1};
    rst_n = 0; cyc = 0; stb = 0; we = 0; adr = 0; dat_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset state", state, 32'h1);
    check("R1 reset ack", {31'b0, ack}, 32'd0);
    rst_n = 1;
    cmp_on = 1;
    repeat (2) @(negedge clk);
    check("R1 held two edges", state, 32'h1);
    repeat (20) @(negedge clk);   // R2 free running
    for (int i = 0; i < 4; i++) begin
      wb_read(3'(i), rd);
      check("R1 seed cleared", {24'b0, rd}, 32'd0);
    end

    // R3 seed bytes
    for (int i = 0; i < 4; i++) wb_write(3'(i), pat[i]);
    for (int i = 0; i < 4; i++) begin
      wb_read(3'(i), rd);
      check("R3 seed readback", {24'b0, rd}, {24'b0, pat[i]});
    end

    // R4 load
    wb_write(3'd4, 8'h02);
    check("R4 loaded seed", state, 32'hE10F_3CA5);
    @(negedge clk);
    check("R4 steps after load", state, ref_step(32'hE10F_3CA5));
    repeat (40) @(negedge clk);

    // R6 reset command and priority
    wb_write(3'd4, 8'h01);
    check("R6 reset command", state, 32'h1);
    repeat (5) @(negedge clk);
    wb_write(3'd4, 8'h03);
    check("R6 reset beats load", state, 32'h1);
    repeat (3) @(negedge clk);
    check("R6 command not sticky", state, ref_step(ref_step(ref_step(32'h1))));

    // R8 high addresses
    for (int a = 4; a < 8; a++) begin
      wb_read(3'(a), rd);
      check("R8 high address reads zero", {24'b0, rd}, 32'd0);
    end
    for (int a = 5; a < 8; a++) wb_write(3'(a), 8'hFF);
    for (int i = 0; i < 4; i++) begin
      wb_read(3'(i), rd);
      check("R8 seed untouched", {24'b0, rd}, {24'b0, pat[i]});
    end

    // R9 strobe without cycle
    @(negedge clk);
    cyc = 0; stb = 1; we = 1; adr = 3'd0; dat_i = 8'h77;
    repeat (2) begin
      @(negedge clk);
      check("R9 no ack without cyc", {31'b0, ack}, 32'd0);
    end
    stb = 0; we = 0;
    wb_read(3'd0, rd);
    check("R9 byte not written", {24'b0, rd}, {24'b0, pat[0]});

    // R5 zero seed
    for (int i = 0; i < 4; i++) wb_write(3'(i), 8'h00);
    repeat (4) @(negedge clk);
    wb_write(3'd4, 8'h02);
    check("R5 zero seed gives one", state, 32'h1);
    repeat (10) @(negedge clk);

    // R1 asynchronous reset mid-run
    wb_write(3'd2, 8'h5A);
    @(negedge clk);
    #1 rst_n = 0;
    #1 check("R1 async reset", state, 32'h1);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    wb_read(3'd2, rd);
    check("R1 seed cleared by reset", {24'b0, rd}, 32'd0);
    repeat (10) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule